// File: doc/BRIEF.md
# Translation Unit Control and Status Registers

This block is the software-facing control plane of a two-level address-translation unit. A 32-bit register port lets software write commands, program the base address of the translation directory and service faults. The block drives the control signals of a separate table walker: paging enable, directory base, stall request, full and single-page cache invalidation pulses, and fault acknowledge. It receives the walker's idle, replay-empty, page-fault and bus-error indications, and raises one interrupt line built from two latched causes and a mask.

Commands are written as small codes to a single command register. A stall request is refused while a page fault is outstanding. The stall is reported as active only once the walker is idle and paging is on. A hard-reset command returns every register to its power-on value, including the directory base. Register reads are combinational from the address. Writes and walker events take effect at the next rising clock edge.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: A write to offset 0x00 stores bits 31..12 of the data as the directory base and clears bits 11..0. Writing 0xCAFEBABE reads back as 0xCAFEB000, and the `dir_base` output shows the same value in the following cycle.
- R2: Command code 0, written to offset 0x08, turns paging on. Code 1 turns it off. Status (offset 0x04) bit 0 and the `paging_en` output show the paging state.
- R3: Command code 2 sets `stall_req` unless a page fault is active. Code 3 clears it. Status bit 2 (stall active) is 1 only while `stall_req` is set and paging is on, and only after the walker has been seen idle with both of those held. Status bit 31 is always the inverse of bit 2.
- R4: A `walk_fault` pulse sets status bit 1 (fault active) and captures `walk_fault_addr` into offset 0x0C. It also captures `walk_fault_write` into status bit 5. Command code 5 clears status bit 1 and raises `fault_done` for exactly one cycle.
- R5: Raw cause register (offset 0x14) bit 0 latches page faults and bit 1 latches bus errors (`walk_bus_err`). Both may be pending together.
- R6: Offset 0x1C holds a 2-bit mask. Offset 0x20 reads raw AND mask, and `irq` is the OR of those bits. Writing 1 to a bit at offset 0x18 clears that raw cause, and an event in the same cycle keeps the cause set.
- R7: Command code 4 raises `zap_all` for one cycle. A write to offset 0x10 raises `zap_page` for one cycle, with `zap_addr` holding the written data with bits 11..0 cleared.
- R8: After reset, and after command code 6, the directory base, paging, stall, fault, raw causes, mask and gating bit are all zero. Status then reads 0x80000000 OR the walker-reflected bits.
- R9: Status bit 3 reflects `walk_idle` and bit 4 reflects `replay_empty`.
- R10: Offsets not listed here read as zero. Writes to the read-only offsets 0x04, 0x0C, 0x14 and 0x20 change nothing. Command codes of 7 or more are ignored.
- R11: Bit 0 of offset 0x24 is a read/write gating enable, driven on `gate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| paging_en | output | 1 | Translation enabled |
| dir_base | output | 32 | Directory base address |
| stall_req | output | 1 | Stall request to walker |
| zap_all | output | 1 | One-cycle full invalidation pulse |
| zap_page | output | 1 | One-cycle single-page invalidation pulse |
| zap_addr | output | 32 | Page address for `zap_page` |
| fault_done | output | 1 | One-cycle fault acknowledge |
| gate_en | output | 1 | Gating enable bit |
| walk_idle | input | 1 | Walker idle |
| replay_empty | input | 1 | Walker replay buffer empty |
| walk_fault | input | 1 | Page fault event |
| walk_fault_write | input | 1 | Faulting access was a write |
| walk_fault_addr | input | 32 | Faulting address |
| walk_bus_err | input | 1 | Bus read error event |
| irq | output | 1 | Interrupt line |

## Verification
The stall handshake is tried with the walker busy and then idle. This separates a stall that waits for idle from one that asserts at once. It is also tried with paging toggled under an active stall and while a fault is pending, which shows whether the refusal and the paging gate work. Interrupts are driven with one cause, then both causes, then under varied masks. A clear is also issued in the same cycle as a new event. Together these tell raw latching apart from masking, and show the set-over-clear priority. Writes to read-only and unused offsets, together with out-of-range codes, show that the decoder ignores them. A hard reset issued after every register has been loaded with non-zero values shows that it reaches all state.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

    localparam int N_CAUSE = 2;

    localparam int OFF_BASE   = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_CMD    = 'h08;
    localparam int OFF_FADDR  = 'h0C;
    localparam int OFF_ZAPONE = 'h10;
    localparam int OFF_RAW    = 'h14;
    localparam int OFF_CLEAR  = 'h18;
    localparam int OFF_MASK   = 'h1C;
    localparam int OFF_STAT   = 'h20;
    localparam int OFF_GATE   = 'h24;

    typedef enum logic [2:0] {
        CMD_PAGE_ON   = 3'd0,
        CMD_PAGE_OFF  = 3'd1,
        CMD_STALL_ON  = 3'd2,
        CMD_STALL_OFF = 3'd3,
        CMD_ZAP_ALL   = 3'd4,
        CMD_FAULT_ACK = 3'd5,
        CMD_HARD_RST  = 3'd6
    } cmd_e;

    localparam int CAUSE_FAULT  = 0;
    localparam int CAUSE_BUSERR = 1;

    typedef struct packed {
        logic paging;
        logic fault_active;
        logic stall_active;
        logic idle;
        logic replay_empty;
        logic fault_write;
    } status_t;

    function automatic logic [31:0] pack_status(status_t s);
        logic [31:0] w;
        w     = '0;
        w[0]  = s.paging;
        w[1]  = s.fault_active;
        w[2]  = s.stall_active;
        w[3]  = s.idle;
        w[4]  = s.replay_empty;
        w[5]  = s.fault_write;
        w[31] = ~s.stall_active;
        return w;
    endfunction

endpackage

// File: rtl/mmu_cmd_seq.sv
module mmu_cmd_seq
    import mmu_regs_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        cmd_valid,
    input  cmd_e        cmd_code,
    input  logic        walk_idle,
    input  logic        walk_fault,
    input  logic        walk_fault_write,
    input  logic [31:0] walk_fault_addr,
    output logic        paging_en,
    output logic        stall_req,
    output logic        stall_shown,
    output logic        fault_active,
    output logic        fault_write,
    output logic [31:0] fault_addr,
    output logic        zap_all,
    output logic        fault_done
);

    logic paging_q, stall_req_q, stall_act_q, fault_q, fwrite_q;
    logic zap_q, done_q;
    logic [31:0] faddr_q;

    logic is_on, is_off, is_st_on, is_st_off, is_zap, is_ack;

    always_comb begin
        is_on     = cmd_valid && (cmd_code == CMD_PAGE_ON);
        is_off    = cmd_valid && (cmd_code == CMD_PAGE_OFF);
        is_st_on  = cmd_valid && (cmd_code == CMD_STALL_ON);
        is_st_off = cmd_valid && (cmd_code == CMD_STALL_OFF);
        is_zap    = cmd_valid && (cmd_code == CMD_ZAP_ALL);
        is_ack    = cmd_valid && (cmd_code == CMD_FAULT_ACK);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            paging_q    <= 1'b0;
            stall_req_q <= 1'b0;
            stall_act_q <= 1'b0;
            fault_q     <= 1'b0;
            fwrite_q    <= 1'b0;
            faddr_q     <= '0;
            zap_q       <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            if (is_on)
                paging_q <= 1'b1;
            else if (is_off)
                paging_q <= 1'b0;

            if (is_st_on && !fault_q)
                stall_req_q <= 1'b1;
            else if (is_st_off)
                stall_req_q <= 1'b0;

            stall_act_q <= stall_req_q && paging_q && (stall_act_q || walk_idle);

            if (walk_fault) begin
                fault_q  <= 1'b1;
                fwrite_q <= walk_fault_write;
                faddr_q  <= walk_fault_addr;
            end else if (is_ack) begin
                fault_q <= 1'b0;
            end

            zap_q  <= is_zap;
            done_q <= is_ack;
        end
    end

    assign paging_en    = paging_q;
    assign stall_req    = stall_req_q;
    assign stall_shown  = stall_act_q && paging_q && stall_req_q;
    assign fault_active = fault_q;
    assign fault_write  = fwrite_q;
    assign fault_addr   = faddr_q;
    assign zap_all      = zap_q;
    assign fault_done   = done_q;

endmodule

// File: rtl/mmu_irq_ctrl.sv
module mmu_irq_ctrl
    import mmu_regs_pkg::*;
(
    input  logic               clk,
    input  logic               clr,
    input  logic [N_CAUSE-1:0] events,
    input  logic               mask_we,
    input  logic [N_CAUSE-1:0] mask_wd,
    input  logic               clear_we,
    input  logic [N_CAUSE-1:0] clear_wd,
    output logic [N_CAUSE-1:0] raw,
    output logic [N_CAUSE-1:0] mask,
    output logic [N_CAUSE-1:0] masked,
    output logic               irq
);

    logic [N_CAUSE-1:0] raw_q, mask_q;

    for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (clr)
                raw_q[i] <= 1'b0;
            else if (events[i])
                raw_q[i] <= 1'b1;
            else if (clear_we && clear_wd[i])
                raw_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= mask_wd;
    end

    assign raw    = raw_q;
    assign mask   = mask_q;
    assign masked = raw_q & mask_q;
    assign irq    = |(raw_q & mask_q);

endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
    import mmu_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              paging_en,
    output logic [31:0]       dir_base,
    output logic              stall_req,
    output logic              zap_all,
    output logic              zap_page,
    output logic [31:0]       zap_addr,
    output logic              fault_done,
    output logic              gate_en,
    input  logic              walk_idle,
    input  logic              replay_empty,
    input  logic              walk_fault,
    input  logic              walk_fault_write,
    input  logic [31:0]       walk_fault_addr,
    input  logic              walk_bus_err,
    output logic              irq
);

    localparam int HI_W = 32 - PAGE_BITS;

    logic sel_base, sel_cmd, sel_zap, sel_clear, sel_mask, sel_gate;
    logic cmd_valid, hard_rst, clr;
    cmd_e cmd_code;

    always_comb begin
        sel_base  = wr_en && (addr == ADDR_W'(OFF_BASE));
        sel_cmd   = wr_en && (addr == ADDR_W'(OFF_CMD));
        sel_zap   = wr_en && (addr == ADDR_W'(OFF_ZAPONE));
        sel_clear = wr_en && (addr == ADDR_W'(OFF_CLEAR));
        sel_mask  = wr_en && (addr == ADDR_W'(OFF_MASK));
        sel_gate  = wr_en && (addr == ADDR_W'(OFF_GATE));
        cmd_valid = sel_cmd && (wdata <= 32'(CMD_HARD_RST));
        cmd_code  = cmd_e'(wdata[2:0]);
        hard_rst  = cmd_valid && (cmd_code == CMD_HARD_RST);
        clr       = rst || hard_rst;
    end

    logic            stall_shown, fault_active, fault_write;
    logic [31:0]     fault_addr;

    mmu_cmd_seq i_seq (
        .clk              (clk),
        .clr              (clr),
        .cmd_valid        (cmd_valid),
        .cmd_code         (cmd_code),
        .walk_idle        (walk_idle),
        .walk_fault       (walk_fault),
        .walk_fault_write (walk_fault_write),
        .walk_fault_addr  (walk_fault_addr),
        .paging_en        (paging_en),
        .stall_req        (stall_req),
        .stall_shown      (stall_shown),
        .fault_active     (fault_active),
        .fault_write      (fault_write),
        .fault_addr       (fault_addr),
        .zap_all          (zap_all),
        .fault_done       (fault_done)
    );

    logic [N_CAUSE-1:0] events, raw, mask, masked;

    always_comb begin
        events               = '0;
        events[CAUSE_FAULT]  = walk_fault;
        events[CAUSE_BUSERR] = walk_bus_err;
    end

    mmu_irq_ctrl i_irq (
        .clk      (clk),
        .clr      (clr),
        .events   (events),
        .mask_we  (sel_mask),
        .mask_wd  (wdata[N_CAUSE-1:0]),
        .clear_we (sel_clear),
        .clear_wd (wdata[N_CAUSE-1:0]),
        .raw      (raw),
        .mask     (mask),
        .masked   (masked),
        .irq      (irq)
    );

    logic [HI_W-1:0] base_q, zap_hi_q;
    logic            zap_pg_q, gate_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            base_q   <= '0;
            zap_hi_q <= '0;
            zap_pg_q <= 1'b0;
            gate_q   <= 1'b0;
        end else begin
            if (sel_base)
                base_q <= wdata[31:PAGE_BITS];
            if (sel_zap)
                zap_hi_q <= wdata[31:PAGE_BITS];
            zap_pg_q <= sel_zap;
            if (sel_gate)
                gate_q <= wdata[0];
        end
    end

    assign dir_base = {base_q, {PAGE_BITS{1'b0}}};
    assign zap_addr = {zap_hi_q, {PAGE_BITS{1'b0}}};
    assign zap_page = zap_pg_q;
    assign gate_en  = gate_q;

    status_t st;

    always_comb begin
        st.paging       = paging_en;
        st.fault_active = fault_active;
        st.stall_active = stall_shown;
        st.idle         = walk_idle;
        st.replay_empty = replay_empty;
        st.fault_write  = fault_write;

        rdata = '0;
        if (addr == ADDR_W'(OFF_BASE))
            rdata = dir_base;
        else if (addr == ADDR_W'(OFF_STATUS))
            rdata = pack_status(st);
        else if (addr == ADDR_W'(OFF_FADDR))
            rdata = fault_addr;
        else if (addr == ADDR_W'(OFF_RAW))
            rdata = 32'(raw);
        else if (addr == ADDR_W'(OFF_MASK))
            rdata = 32'(mask);
        else if (addr == ADDR_W'(OFF_STAT))
            rdata = 32'(masked);
        else if (addr == ADDR_W'(OFF_GATE))
            rdata = {31'b0, gate_q};
    end

endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              paging_en,
    input logic [31:0]       dir_base,
    input logic              stall_req,
    input logic              zap_all,
    input logic              zap_page,
    input logic              fault_done,
    input logic              fault_active,
    input logic              irq
);

    logic wr_cmd, wr_base, wr_zap, wr_mask, rd_status;

    always_comb begin
        wr_cmd    = wr_en && (addr == ADDR_W'(8'h08));
        wr_base   = wr_en && (addr == ADDR_W'(8'h00));
        wr_zap    = wr_en && (addr == ADDR_W'(8'h10));
        wr_mask   = wr_en && (addr == ADDR_W'(8'h1C));
        rd_status = (addr == ADDR_W'(8'h04));
    end

    AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_base |=> (dir_base[31:PAGE_BITS] == $past(wdata[31:PAGE_BITS])) && (dir_base[PAGE_BITS-1:0] == '0)); // R1

    AST_PAGING_ON: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wdata == 32'd0) |=> paging_en); // R2

    AST_STALL_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wdata == 32'd2 && fault_active && !stall_req) |=> !stall_req); // R3

    AST_STALL_NEEDS_PAGING: assert property (@(posedge clk) disable iff (rst)
        (rd_status && rdata[2]) |-> (paging_en && stall_req)); // R3

    AST_STALL_INVERSE: assert property (@(posedge clk) disable iff (rst)
        rd_status |-> (rdata[31] != rdata[2])); // R3

    AST_DONE_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        fault_done |-> $past(wr_cmd && wdata == 32'd5)); // R4

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && wdata[1:0] == 2'b00) |=> !irq); // R6

    AST_ZAP_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        zap_all |-> $past(wr_cmd && wdata == 32'd4)); // R7

    AST_ZAP_PAGE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        zap_page |-> $past(wr_zap)); // R7

    AST_HARD_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wdata == 32'd6) |=> (dir_base == '0 && !paging_en && !stall_req && !irq)); // R8

endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .paging_en    (paging_en),
    .dir_base     (dir_base),
    .stall_req    (stall_req),
    .zap_all      (zap_all),
    .zap_page     (zap_page),
    .fault_done   (fault_done),
    .fault_active (fault_active),
    .irq          (irq)
);

// File: tb/test_mmu_ctrl_regs.sv
module test_mmu_ctrl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              paging_en, stall_req, zap_all, zap_page, fault_done, gate_en, irq;
    logic [31:0]       dir_base, zap_addr;
    logic              walk_idle = 1'b0;
    logic              replay_empty = 1'b0;
    logic              walk_fault = 1'b0;
    logic              walk_fault_write = 1'b0;
    logic [31:0]       walk_fault_addr = '0;
    logic              walk_bus_err = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_ctrl_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(12)) i_mmu_ctrl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .paging_en(paging_en), .dir_base(dir_base), .stall_req(stall_req),
        .zap_all(zap_all), .zap_page(zap_page), .zap_addr(zap_addr),
        .fault_done(fault_done), .gate_en(gate_en), .walk_idle(walk_idle),
        .replay_empty(replay_empty), .walk_fault(walk_fault),
        .walk_fault_write(walk_fault_write), .walk_fault_addr(walk_fault_addr),
        .walk_bus_err(walk_bus_err), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic fault_pulse(input logic [31:0] fa, input logic w);
        @(negedge clk);
        walk_fault = 1'b1; walk_fault_addr = fa; walk_fault_write = w;
        @(negedge clk);
        walk_fault = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h04, d);
        check("R8 status after reset", d, 32'h8000_0000);
        check("R8 dir_base after reset", dir_base, 32'h0);
        check("R8 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_base();
        logic [31:0] d;
        wr(8'h00, 32'hCAFE_BABE);
        rd(8'h00, d);
        check("R1 base readback", d, 32'hCAFE_B000);
        check("R1 dir_base out", dir_base, 32'hCAFE_B000);
    endtask

    task automatic t_paging();
        logic [31:0] d;
        wr(8'h08, 32'd0);
        rd(8'h04, d);
        check("R2 status bit0 on", {31'b0, d[0]}, 32'h1);
        check("R2 paging_en on", {31'b0, paging_en}, 32'h1);
        wr(8'h08, 32'd1);
        rd(8'h04, d);
        check("R2 status bit0 off", {31'b0, d[0]}, 32'h0);
        check("R2 paging_en off", {31'b0, paging_en}, 32'h0);
    endtask

    task automatic t_stall();
        logic [31:0] d;
        walk_idle = 1'b0;
        wr(8'h08, 32'd0);
        wr(8'h08, 32'd2);
        check("R3 stall_req set", {31'b0, stall_req}, 32'h1);
        rd(8'h04, d);
        check("R3 busy walker no stall", {d[31], d[2]}, 32'h2);
        walk_idle = 1'b1;
        @(negedge clk);
        rd(8'h04, d);
        check("R3 stall active when idle", {d[31], d[2]}, 32'h1);
        check("R9 idle bit3", {31'b0, d[3]}, 32'h1);
        wr(8'h08, 32'd1);
        rd(8'h04, d);
        check("R3 stall hidden when paging off", {d[31], d[2]}, 32'h2);
        wr(8'h08, 32'd0);
        @(negedge clk);
        rd(8'h04, d);
        check("R3 stall back with paging", {d[31], d[2]}, 32'h1);
        wr(8'h08, 32'd3);
        rd(8'h04, d);
        check("R3 stall off", {stall_req, d[31], d[2]}, 32'h2);
        replay_empty = 1'b1;
        walk_idle = 1'b0;
        #1;
        rd(8'h04, d);
        check("R9 replay bit4 idle bit3", {d[4], d[3]}, 32'h2);
        replay_empty = 1'b0;
    endtask

    task automatic t_fault();
        logic [31:0] d;
        fault_pulse(32'h1234_5678, 1'b1);
        rd(8'h04, d);
        check("R4 fault active and write", {d[5], d[1]}, 32'h3);
        rd(8'h0C, d);
        check("R4 fault addr", d, 32'h1234_5678);
        rd(8'h14, d);
        check("R5 raw fault cause", d, 32'h1);
        check("R6 irq masked off", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'd2);
        check("R3 stall refused in fault", {31'b0, stall_req}, 32'h0);
        wr(8'h08, 32'd5);
        check("R4 fault_done pulse", {31'b0, fault_done}, 32'h1);
        rd(8'h04, d);
        check("R4 fault cleared", {31'b0, d[1]}, 32'h0);
        @(negedge clk);
        check("R4 fault_done one cycle", {31'b0, fault_done}, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h1C, 32'h3);
        check("R6 irq with fault pending", {31'b0, irq}, 32'h1);
        rd(8'h20, d);
        check("R6 masked status fault", d, 32'h1);
        @(negedge clk);
        walk_bus_err = 1'b1;
        @(negedge clk);
        walk_bus_err = 1'b0;
        rd(8'h14, d);
        check("R5 both causes pending", d, 32'h3);
        wr(8'h1C, 32'h2);
        rd(8'h20, d);
        check("R6 masked status only bus", d, 32'h2);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h18; wdata = 32'h2; walk_bus_err = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; walk_bus_err = 1'b0;
        rd(8'h14, d);
        check("R6 event beats clear", d, 32'h3);
        wr(8'h18, 32'h2);
        rd(8'h20, d);
        check("R6 cleared bus masked", d, 32'h0);
        check("R6 irq low after clear", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h1);
        rd(8'h14, d);
        check("R6 raw all clear", d, 32'h0);
    endtask

    task automatic t_zap();
        wr(8'h08, 32'd4);
        check("R7 zap_all pulse", {31'b0, zap_all}, 32'h1);
        @(negedge clk);
        check("R7 zap_all one cycle", {31'b0, zap_all}, 32'h0);
        wr(8'h10, 32'h0000_5ABC);
        check("R7 zap_page pulse", {31'b0, zap_page}, 32'h1);
        check("R7 zap_addr", zap_addr, 32'h0000_5000);
        @(negedge clk);
        check("R7 zap_page one cycle", {31'b0, zap_page}, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(8'h0C, 32'h0);
        wr(8'h14, 32'h3);
        wr(8'h20, 32'h3);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h0C, d);
        check("R10 fault addr unchanged", d, 32'h1234_5678);
        rd(8'h14, d);
        check("R10 raw unchanged", d, 32'h0);
        rd(8'h04, d);
        check("R10 status unchanged", d, 32'h8000_0020);
        rd(8'h28, d);
        check("R10 unused reads zero", d, 32'h0);
        rd(8'h02, d);
        check("R10 misaligned reads zero", d, 32'h0);
        wr(8'h08, 32'd7);
        wr(8'h08, 32'h0000_0100);
        check("R10 bad codes ignored", {31'b0, paging_en}, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr(8'h24, 32'h1);
        rd(8'h24, d);
        check("R11 gate readback", d, 32'h1);
        check("R11 gate_en out", {31'b0, gate_en}, 32'h1);
    endtask

    task automatic t_hard();
        logic [31:0] d;
        walk_idle = 1'b1;
        wr(8'h00, 32'h8765_4321);
        wr(8'h08, 32'd0);
        wr(8'h08, 32'd2);
        wr(8'h1C, 32'h3);
        fault_pulse(32'h0000_0ABC, 1'b1);
        check("R8 pre-reset irq", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'd6);
        check("R8 base zero", dir_base, 32'h0);
        check("R8 outputs idle", {28'b0, paging_en, stall_req, gate_en, irq}, 32'h0);
        rd(8'h04, d);
        check("R8 status power-on", d, 32'h8000_0008);
        rd(8'h1C, d);
        check("R8 mask zero", d, 32'h0);
        rd(8'h0C, d);
        check("R8 fault addr zero", d, 32'h0);
        rd(8'h14, d);
        check("R8 raw zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_base();
        t_paging();
        t_stall();
        wr(8'h08, 32'd1);
        t_fault();
        t_irq();
        t_zap();
        t_readonly();
        t_gate();
        t_hard();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule